// File: doc/BRIEF.md
# Descriptor Ring Controller for a Host-Memory DMA Engine

This block walks a ring of DMA descriptors that software keeps in host memory. Software sets three values through a small register port: a table base address, a table size, and an on-chip buffer base. It then writes the index of the final descriptor it wants run into a doorbell register. The controller starts at its current ring index and works through every descriptor up to and including that index. When the index passes the last entry of the table, it wraps to zero.

For each descriptor, the controller reads the 32-byte entry one 32-bit word at a time over a request/response read port. It decodes the source, destination and length, and passes them with the descriptor ID to a data-mover port. After the mover signals done, it writes a status word back into the descriptor's last word in host memory. After the final descriptor of the run, it raises a single one-cycle interrupt request.

A doorbell written while a run is active moves the stopping point, so the run continues without a gap. This supports handing over more descriptors than the table holds.

Top module: `dma_desc_ring_ctrl`

## Requirements
- R1: After reset the block is idle. The status register reads 0 (index 0, not busy, no error) and the table size register reads 128. No read, move, status-write or interrupt request is asserted.
- R2: Descriptor k is fetched as eight 32-bit reads. The reads are issued in order at table_base + 32*k + 4*j for j = 0..7. Each address is held stable until its response arrives.
- R3: Word 0 of a descriptor is the source address and word 2 is the byte length. The destination is onchip_base + word 1. These values and the descriptor ID are presented with a one-cycle mv_start pulse, and the block then waits for mv_done.
- R4: After mv_done, the block writes a status word to table_base + 32*k + 28. Bit 0 (done) is 1 and bit 1 is the length-error flag. The request is held with a stable address until it is acknowledged.
- R5: A doorbell (register 3, index in bits 6:0) processes descriptors from the current index through the written index, inclusive. The next run starts at the index after the previous final one.
- R6: After the descriptor whose index equals table_size-1 (register 2, bits 7:0, 1..128), the next index is 0.
- R7: Exactly one interrupt pulse, lasting one cycle, is raised per run. It comes after the final descriptor's status write has been acknowledged.
- R8: A length above 0xFFFFC raises no mv_start. Its status word reads 3 and the sticky error bit in the status register is set. A length of exactly 0xFFFFC is moved normally. The error bit clears on a doorbell written while idle.
- R9: A doorbell written while a run is active replaces the stopping index. The run continues to the new index and raises only one interrupt at the end.
- R10: While busy, writes to the table base (register 0), the on-chip base (register 1) and the table size (register 2) are ignored. Reading them back returns the earlier values.
- R11: The status register (register 4) reports the current index in bits 6:0, busy in bit 8 and the sticky length error in bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| rd_req | output | 1 | Host read request, held until rd_valid |
| rd_addr | output | AW | Host read byte address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| mv_start | output | 1 | One-cycle data-mover start |
| mv_src | output | AW | Move source address |
| mv_dst | output | AW | Move destination address |
| mv_len | output | 32 | Move length in bytes |
| mv_id | output | IDW | Descriptor ID |
| mv_done | input | 1 | Data-mover completion pulse |
| st_req | output | 1 | Status write request, held until st_ack |
| st_addr | output | AW | Status write byte address |
| st_data | output | 32 | Status word |
| st_ack | input | 1 | Status write acknowledge |
| msi_irq | output | 1 | Interrupt request pulse |

## Verification
Some properties are checked on every cycle. The read and status-write addresses must stay steady while their requests wait. The start and interrupt pulses must each last one cycle. The interrupt may only follow an acknowledged status write. Configuration must not change under a write issued while busy. Other behaviour can only be shown by the bench's scenarios, which compare results with a host memory model. These include the exact order of fetch addresses, the decoded move fields, wrapping at a reduced table size, and the rejection of an oversize length with exactly 0xFFFFC accepted. They also include a doorbell arriving mid-run that extends the range and still yields a single interrupt.

// File: rtl/dma_desc_ring_ctrl.sv
`timescale 1ns/1ps
module dma_desc_ring_ctrl #(
  parameter int AW      = 32,
  parameter int IDW     = 7,
  parameter int MAX_LEN = 32'h000F_FFFC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [2:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_valid,
  input  logic [31:0]    rd_data,
  output logic           mv_start,
  output logic [AW-1:0]  mv_src,
  output logic [AW-1:0]  mv_dst,
  output logic [31:0]    mv_len,
  output logic [IDW-1:0] mv_id,
  input  logic           mv_done,
  output logic           st_req,
  output logic [AW-1:0]  st_addr,
  output logic [31:0]    st_data,
  input  logic           st_ack,
  output logic           msi_irq
);
  localparam int DEPTH = 1 << IDW;
  localparam int SZW   = IDW + 1;
  localparam int BEATS = 8;
  localparam int BW    = $clog2(BEATS);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_STAT, S_NEXT, S_IRQ} state_t;

  state_t         state;
  logic [AW-1:0]  tbl_base, loc_base;
  logic [SZW-1:0] tbl_size;
  logic [IDW-1:0] last_q, cur;
  logic [BW-1:0]  beat;
  logic [31:0]    w_src, w_dst, w_len;
  logic           bad_q, err_q;

  logic           busy, db, len_bad, wrap;
  logic [IDW-1:0] eff_last, nxt;
  logic [AW-1:0]  desc_addr;

  assign busy      = (state != S_IDLE);
  assign db        = cfg_wr && (cfg_addr == 3'd3);
  assign eff_last  = db ? cfg_wdata[IDW-1:0] : last_q;
  assign wrap      = (SZW'(cur) + SZW'(1) >= tbl_size) || (cur == {IDW{1'b1}});
  assign nxt       = wrap ? '0 : cur + IDW'(1);
  assign len_bad   = w_len > 32'(MAX_LEN);
  assign desc_addr = tbl_base + AW'({cur, 5'b00000});

  assign rd_req   = (state == S_FETCH);
  assign rd_addr  = desc_addr + AW'({beat, 2'b00});
  assign mv_start = (state == S_ISSUE) && !len_bad;
  assign mv_src   = AW'(w_src);
  assign mv_dst   = loc_base + AW'(w_dst);
  assign mv_len   = w_len;
  assign mv_id    = cur;
  assign st_req   = (state == S_STAT);
  assign st_addr  = desc_addr + AW'(28);
  assign st_data  = {30'd0, bad_q, 1'b1};
  assign msi_irq  = (state == S_IRQ);

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      3'd0: cfg_rdata = 32'(tbl_base);
      3'd1: cfg_rdata = 32'(loc_base);
      3'd2: cfg_rdata = 32'(tbl_size);
      3'd3: cfg_rdata = 32'(last_q);
      3'd4: begin
        cfg_rdata[IDW-1:0] = cur;
        cfg_rdata[8]       = busy;
        cfg_rdata[9]       = err_q;
      end
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base <= '0;
      loc_base <= '0;
      tbl_size <= SZW'(DEPTH);
      last_q   <= '0;
    end else if (cfg_wr) begin
      if (!busy && cfg_addr == 3'd0) tbl_base <= AW'(cfg_wdata);
      if (!busy && cfg_addr == 3'd1) loc_base <= AW'(cfg_wdata);
      if (!busy && cfg_addr == 3'd2) tbl_size <= cfg_wdata[SZW-1:0];
      if (cfg_addr == 3'd3)          last_q   <= cfg_wdata[IDW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      beat  <= '0;
      w_src <= '0;
      w_dst <= '0;
      w_len <= '0;
      bad_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (db) begin
          state <= S_FETCH;
          beat  <= '0;
          err_q <= 1'b0;
        end
        S_FETCH: if (rd_valid) begin
          case (beat)
            BW'(0): w_src <= rd_data;
            BW'(1): w_dst <= rd_data;
            BW'(2): w_len <= rd_data;
            default: ;
          endcase
          beat <= beat + BW'(1);
          if (beat == BW'(BEATS - 1)) state <= S_ISSUE;
        end
        S_ISSUE: begin
          bad_q <= len_bad;
          if (len_bad) begin
            err_q <= 1'b1;
            state <= S_STAT;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (mv_done) state <= S_STAT;
        S_STAT: if (st_ack) state <= S_NEXT;
        S_NEXT: begin
          cur   <= nxt;
          beat  <= '0;
          state <= (cur == eff_last) ? S_IRQ : S_FETCH;
        end
        S_IRQ: begin
          beat  <= '0;
          state <= db ? S_FETCH : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  p_st_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_req && !st_ack |=> st_req && $stable(st_addr));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_irq |=> !msi_irq);

  p_irq_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_irq |-> $past(st_req && st_ack, 2));

  p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_wr && (cfg_addr == 3'd0 || cfg_addr == 3'd2) |=>
      $stable(tbl_base) && $stable(tbl_size));
endmodule

// File: tb/dma_desc_ring_ctrl_bench.sv
`timescale 1ns/1ps
module dma_desc_ring_ctrl_bench;
  localparam logic [31:0] HBASE = 32'h0004_0000;
  localparam logic [31:0] LBASE = 32'h0020_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_req, mv_start, st_req, msi_irq;
  logic [31:0] rd_addr, mv_src, mv_dst, mv_len, st_addr, st_data;
  logic [6:0]  mv_id;
  logic        rd_valid = 1'b0, mv_done = 1'b0, st_ack = 1'b0;
  logic [31:0] rd_data = '0;

  dma_desc_ring_ctrl u_dma_desc_ring_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len), .mv_id(mv_id),
    .mv_done(mv_done),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_ack(st_ack),
    .msi_irq(msi_irq)
  );

  logic [31:0] mem [0:1023];
  int rd_n = 0, mv_n = 0, wr_n = 0, irq_n = 0, irq_wr_snap = 0, mv_cnt = 0;
  logic [31:0] rd_log [0:255];
  logic [31:0] mv_log_src [0:63], mv_log_dst [0:63], mv_log_len [0:63], mv_log_id [0:63];
  logic [31:0] wr_log_addr [0:63], wr_log_data [0:63];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rd_req && !rd_valid) begin
      rd_valid <= 1'b1;
      rd_data  <= mem[rd_addr[11:2]];
      rd_log[rd_n % 256] <= rd_addr;
      rd_n <= rd_n + 1;
    end else rd_valid <= 1'b0;
    if (st_req && !st_ack) begin
      st_ack <= 1'b1;
      mem[st_addr[11:2]] <= st_data;
      wr_log_addr[wr_n % 64] <= st_addr;
      wr_log_data[wr_n % 64] <= st_data;
      wr_n <= wr_n + 1;
    end else st_ack <= 1'b0;
    mv_done <= 1'b0;
    if (mv_start) begin
      mv_log_src[mv_n % 64] <= mv_src;
      mv_log_dst[mv_n % 64] <= mv_dst;
      mv_log_len[mv_n % 64] <= mv_len;
      mv_log_id[mv_n % 64]  <= 32'(mv_id);
      mv_n   <= mv_n + 1;
      mv_cnt <= 3;
    end else if (mv_cnt > 0) begin
      mv_cnt <= mv_cnt - 1;
      if (mv_cnt == 1) mv_done <= 1'b1;
    end
    if (msi_irq) begin
      irq_n <= irq_n + 1;
      irq_wr_snap <= wr_n;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_desc(input int id, input logic [31:0] len);
    mem[id*8 + 0] = 32'hA000_0000 + 32'(id) * 32'h100;
    mem[id*8 + 1] = 32'(id) * 32'h40;
    mem[id*8 + 2] = len;
    for (int j = 3; j < 8; j++) mem[id*8 + j] = 32'h0;
  endtask

  task automatic wait_irq(input int target);
    for (int i = 0; i < 5000 && irq_n < target; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic check_moves(input string req, input int base, input int n, input int first, input int size);
    int id = first;
    for (int i = 0; i < n; i++) begin
      chk(req, mv_log_id[(base + i) % 64], 32'(id));
      chk(req, mv_log_src[(base + i) % 64], 32'hA000_0000 + 32'(id) * 32'h100);
      chk(req, mv_log_dst[(base + i) % 64], LBASE + 32'(id) * 32'h40);
      id = (id + 1 >= size) ? 0 : id + 1;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(3'd4, v); chk("R1 status after reset", v, 32'h0);
    reg_read(3'd2, v); chk("R1 size after reset", v, 32'd128);
    chk("R1 outputs idle", {28'd0, rd_req, mv_start, st_req, msi_irq}, 32'h0);
    reg_read(3'd4, v); chk("R11 status idle", v, 32'h0);
  endtask

  task automatic t_basic;
    int m0 = mv_n, r0 = rd_n, w0 = wr_n, i0 = irq_n;
    logic [31:0] v;
    reg_write(3'd0, HBASE);
    reg_write(3'd1, LBASE);
    reg_write(3'd3, 32'd2);
    wait_irq(i0 + 1);
    chk("R5 three moves", 32'(mv_n - m0), 32'd3);
    check_moves("R3 decoded fields", m0, 3, 0, 128);
    for (int i = 0; i < 3; i++) chk("R3 length", mv_log_len[(m0 + i) % 64], 32'h40 + 32'(i) * 4);
    chk("R2 beat count", 32'(rd_n - r0), 32'd24);
    for (int i = 0; i < 24; i++)
      chk("R2 fetch address", rd_log[(r0 + i) % 256], HBASE + 32'(i / 8) * 32 + 32'(i % 8) * 4);
    for (int i = 0; i < 3; i++) begin
      chk("R4 status addr", wr_log_addr[(w0 + i) % 64], HBASE + 32'(i) * 32 + 28);
      chk("R4 status word", mem[i*8 + 7], 32'h1);
    end
    chk("R7 one irq", 32'(irq_n - i0), 32'd1);
    chk("R7 irq after last status", 32'(irq_wr_snap), 32'(wr_n));
    reg_read(3'd4, v); chk("R5 R11 next index idle", v, 32'd3);
  endtask

  task automatic t_busy_cfg;
    int m0 = mv_n, i0 = irq_n;
    logic [31:0] v;
    reg_write(3'd3, 32'd5);
    reg_write(3'd0, 32'h0009_0000);
    reg_write(3'd1, 32'h0000_1000);
    reg_write(3'd2, 32'd4);
    reg_read(3'd0, v); chk("R10 base kept", v, HBASE);
    reg_read(3'd1, v); chk("R10 onchip base kept", v, LBASE);
    reg_read(3'd2, v); chk("R10 size kept", v, 32'd128);
    reg_read(3'd4, v); chk("R11 busy bit", {31'd0, v[8]}, 32'd1);
    wait_irq(i0 + 1);
    chk("R5 moves 3..5", 32'(mv_n - m0), 32'd3);
    check_moves("R10 old config used", m0, 3, 3, 128);
  endtask

  task automatic t_wrap;
    int m0 = mv_n, i0 = irq_n;
    logic [31:0] v;
    reg_write(3'd2, 32'd8);
    reg_write(3'd3, 32'd1);
    wait_irq(i0 + 1);
    chk("R6 wrap count", 32'(mv_n - m0), 32'd4);
    check_moves("R6 wrap order", m0, 4, 6, 8);
    reg_read(3'd4, v); chk("R6 index after wrap", v, 32'd2);
  endtask

  task automatic t_len_err;
    int m0 = mv_n, i0 = irq_n;
    logic [31:0] v;
    set_desc(2, 32'h0010_0000);
    set_desc(3, 32'h000F_FFFC);
    reg_write(3'd3, 32'd3);
    wait_irq(i0 + 1);
    chk("R8 only valid moved", 32'(mv_n - m0), 32'd1);
    chk("R8 moved id", mv_log_id[m0 % 64], 32'd3);
    chk("R8 max length accepted", mv_log_len[m0 % 64], 32'h000F_FFFC);
    chk("R8 error status word", mem[2*8 + 7], 32'h3);
    chk("R8 good status word", mem[3*8 + 7], 32'h1);
    reg_read(3'd4, v); chk("R8 R11 error flag", v, 32'h0000_0204);
    set_desc(2, 32'h48);
    set_desc(3, 32'h4C);
  endtask

  task automatic t_extend;
    int m0 = mv_n, i0 = irq_n;
    logic [31:0] v;
    reg_write(3'd3, 32'd7);
    for (int i = 0; i < 2000 && mv_n == m0; i++) @(negedge clk);
    reg_write(3'd3, 32'd1);
    wait_irq(i0 + 1);
    repeat (200) @(negedge clk);
    chk("R9 extended count", 32'(mv_n - m0), 32'd6);
    check_moves("R9 extended order", m0, 6, 4, 8);
    chk("R9 single irq", 32'(irq_n - i0), 32'd1);
    reg_read(3'd4, v); chk("R9 R8 final status", v, 32'd2);
  endtask

  initial begin
    for (int k = 0; k < 128; k++) set_desc(k, 32'h40 + 32'(k) * 4);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_busy_cfg;
    t_wrap;
    t_len_err;
    t_extend;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule